// File: doc/BRIEF.md
# Selectable-Clock Parallel Input Capture

This block latches a 32-bit parallel input word into a holding register. Software picks when the latch happens. It has three timing sources:

- **Internal prescaler.** A strobe derived from the 33 MHz system clock, at one of five power-of-two rates.
- **Oscillator.** A user oscillator input, used at its own rate or after a power-of-two divider.
- **External clock.** An external clock input from the user.

Software can also pick an external enable level that gates each capture. With the internal enable selected, every capture is allowed.

All logic runs in the system clock domain. The oscillator, external clock and external enable pins are asynchronous. Each passes through a two-flop synchronizer. A rising edge seen at a synchronizer output becomes a one-cycle capture strobe. No clock is ever gated.

The captured word stays on a read-back port. A "new word" flag tells software that a capture has happened since the last read.

Top module: `sampleCapture`

## Requirements
- R1: After reset, `capData` is 0 and `newFlag` is 0.
- R2: With `srcSel`=0 (internal), a capture happens once every 4·2^k system cycles, where k is `rateSel` for values 0..4; `rateSel` values 5..7 behave like 4 (divide by 64).
- R3: A cycle in which `rateSel` differs from its value in the previous cycle restarts the prescaler. No capture happens in that cycle, and the next capture comes exactly one full period later.
- R4: With `srcSel`=1 (oscillator) and `oscDivSel`=0, every rising edge of `oscIn` causes exactly one capture. A level first sampled high at clock edge j, after being low at edge j-1, is captured at edge j+2.
- R5: With `srcSel`=1 and `oscDivSel`=n, a capture happens on every 2^n-th oscillator rising edge. The edge count restarts when `oscDivSel` changes.
- R6: With `srcSel`=2 (external clock), each rising edge of `extClkIn` causes one capture, with the same latency as R4 and no divider.
- R7: With `srcSel`=3, no capture ever happens.
- R8: With `enSrcExt`=1, a strobe captures only if `extEnIn`, sampled two clock edges before the capture edge, was high. Otherwise the strobe is dropped.
- R9: With `enSrcExt`=0, `extEnIn` has no effect on captures.
- R10: `newFlag` rises after each capture and is cleared by `rdStrobe`. A capture in the same cycle as `rdStrobe` leaves the flag set.
- R11: Between captures, `capData` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 33 MHz system clock |
| rstN | input | 1 | Active-low synchronous reset |
| dataIn | input | 32 | Parallel input word |
| oscIn | input | 1 | User oscillator, asynchronous |
| extClkIn | input | 1 | External sample clock, asynchronous |
| extEnIn | input | 1 | External capture enable, asynchronous |
| srcSel | input | 2 | Timing source: 0 internal, 1 oscillator, 2 external, 3 off |
| rateSel | input | 3 | Internal prescaler rate code |
| oscDivSel | input | 3 | Oscillator divide exponent (ratio 2^n) |
| enSrcExt | input | 1 | 1 selects the external enable, 0 the internal one |
| rdStrobe | input | 1 | Data register read; clears `newFlag` |
| capData | output | 32 | Last captured word |
| newFlag | output | 1 | Capture happened since the last read |

## Verification
The bench aims at these corner cases:

- **Clamping of unused rate codes.** A design that decoded codes 5..7 wrongly would sample at the wrong rate.
- **Prescaler restart on a rate change.** Without it, the first capture after the change would come early or late.
- **Oscillator divider counting and restart.** An off-by-one count would give too many or too few captures per window.
- **Synchronizer latency.** Capturing a cycle early or late would latch the wrong word.
- **External enable.** A design that ignored the enable, or used it while the internal enable was selected, would gain or lose captures.
- **Read/capture collision on the flag.** Letting the read win here would lose a new-word notice.

// File: rtl/capPkg.sv
package capPkg;

  typedef enum logic [1:0] {
    SRC_INT = 2'd0,
    SRC_OSC = 2'd1,
    SRC_EXT = 2'd2,
    SRC_OFF = 2'd3
  } capSrcT;

  typedef struct packed {
    logic capture;
    logic clearFlag;
  } capStrobeT;

endpackage

// File: rtl/capEdgeSync.sv
module capEdgeSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic levelOut,
  output logic riseOut
);

  logic [STAGES:0] shiftQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= '0;
    end else begin
      shiftQ <= {shiftQ[STAGES-1:0], asyncIn};
    end
  end

  assign levelOut = shiftQ[STAGES-1];
  assign riseOut  = shiftQ[STAGES-1] & ~shiftQ[STAGES];

  // two consecutive rises are impossible through the edge detector (R4, R6)
  p_rise_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    riseOut |=> !riseOut);

endmodule

// File: rtl/capControl.sv
module capControl
  import capPkg::*;
#(
  parameter int RATE_W       = 3,
  parameter int NUM_RATES    = 5,
  parameter int BASE_DIV_LOG = 2,
  parameter int OSC_DIV_W    = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              oscIn,
  input  logic              extClkIn,
  input  logic              extEnIn,
  input  logic [1:0]        srcSel,
  input  logic [RATE_W-1:0] rateSel,
  input  logic [OSC_DIV_W-1:0] oscDivSel,
  input  logic              enSrcExt,
  input  logic              rdStrobe,
  output capStrobeT         strobe
);

  localparam int PRE_W     = BASE_DIV_LOG + NUM_RATES - 1;
  localparam int OSC_CNT_W = (1 << OSC_DIV_W) - 1;
  localparam int NUM_SYNC  = 3;

  // synchronizers: index 0 osc, 1 ext clock, 2 ext enable
  logic [NUM_SYNC-1:0] rawIn;
  logic [NUM_SYNC-1:0] syncLevel;
  logic [NUM_SYNC-1:0] syncRise;

  assign rawIn = {extEnIn, extClkIn, oscIn};

  for (genvar g = 0; g < NUM_SYNC; g++) begin : gSync
    capEdgeSync #(.STAGES(SYNC_STAGES)) uSync (
      .clk     (clk),
      .rstN    (rstN),
      .asyncIn (rawIn[g]),
      .levelOut(syncLevel[g]),
      .riseOut (syncRise[g])
    );
  end

  logic oscRise, extRise, extEnLevel;
  assign oscRise    = syncRise[0];
  assign extRise    = syncRise[1];
  assign extEnLevel = syncLevel[2];

  // internal prescaler
  logic [RATE_W-1:0] rateEff;
  logic [RATE_W-1:0] lastRate;
  logic [PRE_W-1:0]  preCnt;
  logic [PRE_W-1:0]  preLimit;
  logic              rateChanged;
  logic              intTick;

  always_comb begin
    if (rateSel > RATE_W'(NUM_RATES - 1)) rateEff = RATE_W'(NUM_RATES - 1);
    else                                  rateEff = rateSel;
    preLimit    = PRE_W'((32'd1 << (BASE_DIV_LOG + int'(rateEff))) - 32'd1);
    rateChanged = (rateSel != lastRate);
    intTick     = !rateChanged && (preCnt == preLimit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt   <= '0;
      lastRate <= '0;
    end else begin
      lastRate <= rateSel;
      if (rateChanged || intTick) preCnt <= '0;
      else                        preCnt <= preCnt + 1'b1;
    end
  end

  // oscillator edge divider
  logic [OSC_DIV_W-1:0] lastDiv;
  logic [OSC_CNT_W-1:0] oscCnt;
  logic [OSC_CNT_W-1:0] oscLimit;
  logic                 divChanged;
  logic                 oscTick;

  always_comb begin
    oscLimit   = OSC_CNT_W'((32'd1 << oscDivSel) - 32'd1);
    divChanged = (oscDivSel != lastDiv);
    oscTick    = oscRise && !divChanged && (oscCnt == oscLimit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oscCnt  <= '0;
      lastDiv <= '0;
    end else begin
      lastDiv <= oscDivSel;
      if (divChanged)   oscCnt <= '0;
      else if (oscRise) oscCnt <= oscTick ? '0 : oscCnt + 1'b1;
    end
  end

  // source select and enable qualification
  logic srcStrobe;
  logic enOk;

  always_comb begin
    unique case (capSrcT'(srcSel))
      SRC_INT: srcStrobe = intTick;
      SRC_OSC: srcStrobe = oscTick;
      SRC_EXT: srcStrobe = extRise;
      default: srcStrobe = 1'b0;
    endcase
    enOk            = enSrcExt ? extEnLevel : 1'b1;
    strobe.capture   = srcStrobe && enOk;
    strobe.clearFlag = rdStrobe;
  end

  p_no_cap_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == 2'd3) |-> !strobe.capture);

  p_ext_en_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    (enSrcExt && !extEnLevel) |-> !strobe.capture);

  p_int_spacing_r2: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == 2'd0 && strobe.capture) |=> !strobe.capture);

  p_restart_r3: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == 2'd0 && rateSel != $past(rateSel)) |-> !strobe.capture);

endmodule

// File: rtl/capDatapath.sv
module capDatapath
  import capPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  capStrobeT         strobe,
  output logic [DATA_W-1:0] capData,
  output logic              newFlag
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capData <= '0;
      newFlag <= 1'b0;
    end else begin
      if (strobe.capture) capData <= dataIn;
      if (strobe.capture)        newFlag <= 1'b1;
      else if (strobe.clearFlag) newFlag <= 1'b0;
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(capData));

  p_flag_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> newFlag);

  p_flag_clr_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clearFlag && !strobe.capture) |=> !newFlag);

endmodule

// File: rtl/sampleCapture.sv
module sampleCapture
  import capPkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int RATE_W       = 3,
  parameter int NUM_RATES    = 5,
  parameter int BASE_DIV_LOG = 2,
  parameter int OSC_DIV_W    = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DATA_W-1:0]    dataIn,
  input  logic                 oscIn,
  input  logic                 extClkIn,
  input  logic                 extEnIn,
  input  logic [1:0]           srcSel,
  input  logic [RATE_W-1:0]    rateSel,
  input  logic [OSC_DIV_W-1:0] oscDivSel,
  input  logic                 enSrcExt,
  input  logic                 rdStrobe,
  output logic [DATA_W-1:0]    capData,
  output logic                 newFlag
);

  capStrobeT strobe;

  capControl #(
    .RATE_W      (RATE_W),
    .NUM_RATES   (NUM_RATES),
    .BASE_DIV_LOG(BASE_DIV_LOG),
    .OSC_DIV_W   (OSC_DIV_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .oscIn    (oscIn),
    .extClkIn (extClkIn),
    .extEnIn  (extEnIn),
    .srcSel   (srcSel),
    .rateSel  (rateSel),
    .oscDivSel(oscDivSel),
    .enSrcExt (enSrcExt),
    .rdStrobe (rdStrobe),
    .strobe   (strobe)
  );

  capDatapath #(.DATA_W(DATA_W)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .dataIn (dataIn),
    .strobe (strobe),
    .capData(capData),
    .newFlag(newFlag)
  );

endmodule

// File: tb/sampleCapture_test.sv
`timescale 1ns/1ps
module sampleCapture_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] dataIn = '0;
  logic        oscIn = 1'b0, extClkIn = 1'b0, extEnIn = 1'b0;
  logic [1:0]  srcSel = 2'd3;
  logic [2:0]  rateSel = '0, oscDivSel = '0;
  logic        enSrcExt = 1'b0, rdStrobe = 1'b0;
  logic [31:0] capData;
  logic        newFlag;

  int total = 0, bad = 0;
  string curReq = "R1";
  int oscPeriod = 0, extPeriod = 0;
  bit rdMode = 0, extEnForce = 0;
  int cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sampleCapture uut (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .oscIn(oscIn), .extClkIn(extClkIn),
    .extEnIn(extEnIn), .srcSel(srcSel), .rateSel(rateSel), .oscDivSel(oscDivSel),
    .enSrcExt(enSrcExt), .rdStrobe(rdStrobe), .capData(capData), .newFlag(newFlag)
  );

  // free-running stimulus, driven away from the active edge
  always @(negedge clk) begin
    cyc++;
    dataIn = cyc * 32'h0001_0003 + 32'h55;
    oscIn = (oscPeriod > 0) ? ((cyc % oscPeriod) < oscPeriod / 2) : 1'b0;
    extClkIn = (extPeriod > 0) ? ((cyc % extPeriod) < extPeriod / 2) : 1'b0;
    extEnIn = extEnForce;
    rdStrobe = rdMode ? ((cyc % 3) == 0) : 1'b0;
  end

  // behavioural reference model
  bit oq[4], eq[4], nq[4];
  int mPre, mOsc, mRate, mDiv;
  logic [31:0] expData;
  bit expNew;

  always @(posedge clk) begin
    bit oR, eR, enL, iTick, oTick, stb, cap;
    int div;
    if (!rstN) begin
      oq = '{default: 0}; eq = '{default: 0}; nq = '{default: 0};
      mPre = 0; mOsc = 0; mRate = 0; mDiv = 0;
      expData = '0; expNew = 0;
    end else begin
      oR = oq[1] && !oq[2];
      eR = eq[1] && !eq[2];
      enL = nq[1];
      if (int'(rateSel) != mRate) begin iTick = 0; mPre = 0; end
      else begin
        div = 4 << ((rateSel > 4) ? 4 : int'(rateSel));
        iTick = (mPre == div - 1);
        mPre = iTick ? 0 : mPre + 1;
      end
      mRate = int'(rateSel);
      oTick = 0;
      if (int'(oscDivSel) != mDiv) mOsc = 0;
      else if (oR) begin
        oTick = (mOsc == (1 << oscDivSel) - 1);
        mOsc = oTick ? 0 : mOsc + 1;
      end
      mDiv = int'(oscDivSel);
      case (srcSel)
        2'd0: stb = iTick;
        2'd1: stb = oTick;
        2'd2: stb = eR;
        default: stb = 0;
      endcase
      cap = stb && (!enSrcExt || enL);
      if (cap) expData = dataIn;
      if (cap) expNew = 1; else if (rdStrobe) expNew = 0;
      for (int i = 3; i > 0; i--) begin oq[i] = oq[i-1]; eq[i] = eq[i-1]; nq[i] = nq[i-1]; end
      oq[0] = oscIn; eq[0] = extClkIn; nq[0] = extEnIn;
    end
  end

  task automatic check(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(curReq, "capData vs model", capData, expData);
      check(curReq, "newFlag vs model", newFlag, expNew);
    end
  end

  task automatic countCaps(int n, output int cnt);
    logic [31:0] prev;
    cnt = 0;
    prev = capData;
    repeat (n) begin
      @(negedge clk);
      if (capData != prev) cnt++;
      prev = capData;
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    int c;
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int c, wait_n;
    logic [31:0] prev;
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1", "capData after reset", capData, 0);
    check("R1", "newFlag after reset", newFlag, 0);
    rstN = 1;
    repeat (3) @(negedge clk);

    // R2 internal rates, including clamped codes
    curReq = "R2";
    srcSel = 2'd0;
    for (int r = 0; r < 8; r++) begin
      if (r == 5) r = 6;
      rateSel = 3'(r);
      repeat (70) @(negedge clk);
      countCaps(256, c);
      check("R2", $sformatf("captures at rate code %0d", r), c, 256 / (4 << ((r > 4) ? 4 : r)));
    end

    // R3 restart on rate change: div 8, capture seen at the 9th sample
    curReq = "R3";
    rateSel = 3'd0;
    repeat (20) @(negedge clk);
    rateSel = 3'd1;
    prev = capData;
    wait_n = 0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (capData != prev && wait_n == 0) wait_n = i;
    end
    check("R3", "cycles to first capture after rate change", wait_n, 9);

    // R4 oscillator direct
    curReq = "R4";
    srcSel = 2'd1; oscDivSel = 3'd0; oscPeriod = 6;
    repeat (20) @(negedge clk);
    countCaps(60, c);
    check("R4", "oscillator direct captures", c, 10);

    // R5 oscillator divided by 4 and by 2
    curReq = "R5";
    oscDivSel = 3'd2;
    repeat (30) @(negedge clk);
    countCaps(240, c);
    check("R5", "oscillator /4 captures", c, 10);
    oscDivSel = 3'd1;
    repeat (30) @(negedge clk);
    countCaps(120, c);
    check("R5", "oscillator /2 captures", c, 10);

    // R6 external clock
    curReq = "R6";
    oscPeriod = 0; srcSel = 2'd2; extPeriod = 10;
    repeat (20) @(negedge clk);
    countCaps(100, c);
    check("R6", "external clock captures", c, 10);

    // R7 / R11 source off: data held
    curReq = "R7";
    srcSel = 2'd3;
    repeat (5) @(negedge clk);
    prev = capData;
    countCaps(100, c);
    check("R7", "captures with source off", c, 0);
    check("R11", "capData held while idle", capData, prev);

    // R8 external enable low then high
    curReq = "R8";
    extPeriod = 0; srcSel = 2'd0; rateSel = 3'd0; enSrcExt = 1; extEnForce = 0;
    repeat (10) @(negedge clk);
    countCaps(100, c);
    check("R8", "captures with external enable low", c, 0);
    extEnForce = 1;
    repeat (10) @(negedge clk);
    countCaps(100, c);
    check("R8", "captures with external enable high", c, 25);

    // R9 internal enable ignores external pin
    curReq = "R9";
    enSrcExt = 0; extEnForce = 0;
    repeat (10) @(negedge clk);
    countCaps(100, c);
    check("R9", "captures with internal enable, pin low", c, 25);

    // R10 flag: reads interleaved with captures, then clear with source off
    curReq = "R10";
    rdMode = 1;
    repeat (200) @(negedge clk);
    srcSel = 2'd3;
    repeat (6) @(negedge clk);
    check("R10", "flag cleared by read", newFlag, 0);
    rdMode = 0;
    srcSel = 2'd0;
    repeat (6) @(negedge clk);
    check("R10", "flag set after capture", newFlag, 1);

    finish_run();
  end

endmodule